// File: doc/BRIEF.md
# I2C Bit-Rate Prescaler

This block turns the system clock into the timing tick that an I2C master's SCL phase sequencer uses to place its SCL edges and SDA transitions. The tick comes at ten times the SCL rate. The divide ratio is set by a write-only rate byte. That byte holds two fields: a linear multiplier field M and an exponent field N. The total ratio is (M+1) × 2^(N+1) system clocks per tick. A build-time parameter switches the exponent to 2^N. The resulting SCL frequency is therefore f_clk / (10 × (M+1) × 2^(N+1)).

The divider has two stages. A linear stage emits one pulse every M+1 clocks. A power-of-two stage passes one of every 2^(N+1) of those pulses to the tick output. Software writes a new rate byte at any time. The new value is held as pending and moves into use only when the current tick period ends, so no period is ever cut short. While the core enable is low, both counters stay cleared and the pending value is copied into use on every cycle.

Top module: `i2c_bitrate_prescaler`

## Requirements
- R1: With the default build, one tick occurs every (M+1) × 2^(N+1) enabled clocks. M is rate-byte bits 6:3 and N is bits 2:0. Bit 7 has no effect.
- R2: The tick is a pulse one clock wide whenever the period is longer than one clock.
- R3: After reset the rate byte is 0x44 (M=8, N=4). The first tick then comes on the 288th enabled cycle, and later ticks every 288 cycles.
- R4: While the core enable is low, no tick is produced and both counters are cleared. After enable rises, the first tick comes on the P-th enabled cycle, where P is the period in use.
- R5: A rate written while enabled does not change the period in progress. It takes effect from the clock after the next tick.
- R6: A rate written while the core enable is low is the one in use from the first enabled cycle.
- R7: With the alternate exponent build, the period is (M+1) × 2^N. With M=0 and N=0 this makes the tick high on every enabled cycle.
- R8: The extreme settings M=15, N=7 give a period of 4096 clocks (2048 in the alternate build), and M=0, N=0 gives a period of 2 clocks (1 in the alternate build).

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Synchronous active-low reset |
| core_en | input | 1 | Core enable; low holds the dividers cleared |
| baud_wr | input | 1 | Write strobe for the rate byte |
| baud_data | input | 8 | Rate byte: N in bits 2:0, M in bits 6:3, bit 7 unused |
| tick | output | 1 | One-clock pulse at ten times the SCL rate |

## Verification
The hardest case to reach from the ports is a rate write that lands partway through a long period. The old period must run out at its full length before the new one starts. The stimulus writes new rates a few cycles after a tick, and also on the cycle just before a tick, with long and short settings on either side. It then compares every cycle against a reference model that counts a single period length. Enable is also dropped in the middle of a period, which covers both the counter restart and the load path used while disabled.

// File: rtl/i2c_presc_pkg.sv
// Shared field layout and reset value for the I2C bit-rate prescaler.
// Assumes an 8-bit rate byte with N in the low bits and M above it.
package i2c_presc_pkg;
    localparam int BAUD_W = 8;
    localparam int M_W    = 4;
    localparam int N_W    = 3;
    localparam int N_LSB  = 0;
    localparam int M_LSB  = N_W;
    // widest power-of-two counter: exponent up to 2**N_W needs that many bits
    localparam int POW_W  = 1 << N_W;
    localparam logic [BAUD_W-1:0] BAUD_RESET = 8'h44;

    typedef struct packed {
        logic [M_W-1:0] m;
        logic [N_W-1:0] n;
    } rate_t;

    // Split a rate byte into its two divider fields.
    function automatic rate_t decode_rate(input logic [BAUD_W-1:0] b);
        rate_t r;
        r.m = b[M_LSB +: M_W];
        r.n = b[N_LSB +: N_W];
        return r;
    endfunction
endpackage

// File: rtl/presc_rate_reg.sv
// Rate holding logic: a pending copy written by software and an active
// copy that the dividers use. The active copy is refreshed only when
// load_i is high (tick boundary or core disabled).
// Assumes load_i is driven from registered state only.
module presc_rate_reg
    import i2c_presc_pkg::*;
(
    input  logic              clk,
    input  logic              rst_n,
    input  logic              wr_en_i,
    input  logic [BAUD_W-1:0] wr_data_i,
    input  logic              load_i,
    output rate_t             act_o
);
    rate_t pend_q;
    rate_t act_q;

    // capture software writes into the pending copy
    always_ff @(posedge clk) begin
        if (!rst_n)       pend_q <= decode_rate(BAUD_RESET);
        else if (wr_en_i) pend_q <= decode_rate(wr_data_i);
    end

    // move pending into use at a period boundary
    always_ff @(posedge clk) begin
        if (!rst_n)      act_q <= decode_rate(BAUD_RESET);
        else if (load_i) act_q <= pend_q;
    end

    assign act_o = act_q;
endmodule

// File: rtl/presc_linear_stage.sv
// First divider stage: one pulse every m_i+1 enabled clocks.
// Assumes m_i only changes on a cycle where pulse_o is high or enable is low.
module presc_linear_stage
    import i2c_presc_pkg::*;
(
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic [M_W-1:0] m_i,
    output logic           pulse_o
);
    logic [M_W-1:0] cnt_q;

    // count 0..m_i, wrapping; cleared while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)                       cnt_q <= '0;
        else if (!enable || cnt_q == m_i) cnt_q <= '0;
        else                              cnt_q <= cnt_q + 1'b1;
    end

    assign pulse_o = enable && (cnt_q == m_i);

    // R1
    lin_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= m_i);
    // R4
    lin_quiet_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !enable |-> !pulse_o);
endmodule

// File: rtl/presc_pow2_stage.sv
// Second divider stage: passes one of every 2**E step pulses to tick_o.
// E is n_i+1 or n_i, chosen at build time by EXP_PLUS_ONE.
// Assumes n_i only changes on a tick or while disabled.
module presc_pow2_stage
    import i2c_presc_pkg::*;
#(
    parameter bit EXP_PLUS_ONE = 1'b1
) (
    input  logic           clk,
    input  logic           rst_n,
    input  logic           enable,
    input  logic           step_i,
    input  logic [N_W-1:0] n_i,
    output logic           tick_o
);
    logic [N_W:0]     expo;
    logic [POW_W:0]   span;
    logic [POW_W-1:0] last;
    logic [POW_W-1:0] cnt_q;

    // exponent variant picked at build time
    generate
        if (EXP_PLUS_ONE) begin : g_exp_plus
            assign expo = {1'b0, n_i} + 1'b1;
        end else begin : g_exp_plain
            assign expo = {1'b0, n_i};
        end
    endgenerate

    assign span = {{POW_W{1'b0}}, 1'b1} << expo;
    assign last = POW_W'(span - 1'b1);

    // count step pulses 0..last, wrapping; cleared while disabled
    always_ff @(posedge clk) begin
        if (!rst_n)         cnt_q <= '0;
        else if (!enable)   cnt_q <= '0;
        else if (step_i)    cnt_q <= (cnt_q == last) ? '0 : cnt_q + 1'b1;
    end

    assign tick_o = step_i && (cnt_q == last);

    // R1
    pow_range_chk: assert property (@(posedge clk) disable iff (!rst_n)
        cnt_q <= last);
    // R5
    pow_restart_chk: assert property (@(posedge clk) disable iff (!rst_n)
        tick_o |=> (cnt_q == '0));
endmodule

// File: rtl/i2c_bitrate_prescaler.sv
// Top of the I2C bit-rate prescaler: rate byte holding, linear stage
// (M+1) and power-of-two stage, producing a one-clock tick at ten times
// the SCL rate. Assumes a synchronous active-low reset and that the rate
// byte is write-only.
module i2c_bitrate_prescaler
    import i2c_presc_pkg::*;
#(
    parameter bit EXP_PLUS_ONE = 1'b1
) (
    input  logic              clk,
    input  logic              rst_n,
    input  logic              core_en,
    input  logic              baud_wr,
    input  logic [BAUD_W-1:0] baud_data,
    output logic              tick
);
    rate_t act;
    logic  lin_pulse;
    logic  load;

    // refresh the active rate at a tick or while the core is off
    assign load = !core_en || tick;

    presc_rate_reg u_rate (
        .clk       (clk),
        .rst_n     (rst_n),
        .wr_en_i   (baud_wr),
        .wr_data_i (baud_data),
        .load_i    (load),
        .act_o     (act)
    );

    presc_linear_stage u_lin (
        .clk     (clk),
        .rst_n   (rst_n),
        .enable  (core_en),
        .m_i     (act.m),
        .pulse_o (lin_pulse)
    );

    presc_pow2_stage #(.EXP_PLUS_ONE(EXP_PLUS_ONE)) u_pow (
        .clk    (clk),
        .rst_n  (rst_n),
        .enable (core_en),
        .step_i (lin_pulse),
        .n_i    (act.n),
        .tick_o (tick)
    );

    // R5
    act_hold_chk: assert property (@(posedge clk) disable iff (!rst_n)
        (core_en && !tick) |=> $stable(act));
    // R4
    tick_off_chk: assert property (@(posedge clk) disable iff (!rst_n)
        !core_en |-> !tick);
endmodule

// File: tb/i2c_bitrate_prescaler_bench.sv
`timescale 1ns/1ps
module i2c_bitrate_prescaler_bench;
    logic       clk = 1'b0;
    logic       rst_n = 1'b0;
    logic       core_en = 1'b0;
    logic       baud_wr = 1'b0;
    logic [7:0] baud_data = 8'h00;
    logic       tick, tick_alt;

    int    total = 0;
    int    bad = 0;
    bit    checking = 1'b0;
    bit    done = 1'b0;
    string cur_req = "R3";

    // reference state: pending byte, active byte, cycles into period
    int pend_b, act_b, cnt;
    int pend_a, act_a, cnt_a;

    always #4 clk = ~clk;

    i2c_bitrate_prescaler u_i2c_bitrate_prescaler (
        .clk(clk), .rst_n(rst_n), .core_en(core_en),
        .baud_wr(baud_wr), .baud_data(baud_data), .tick(tick));

    i2c_bitrate_prescaler #(.EXP_PLUS_ONE(1'b0)) u_i2c_bitrate_prescaler_alt (
        .clk(clk), .rst_n(rst_n), .core_en(core_en),
        .baud_wr(baud_wr), .baud_data(baud_data), .tick(tick_alt));

    // period in clocks from a rate byte (M bits 6:3, N bits 2:0)
    function automatic int period(input int b, input int plus1);
        int m, n;
        m = (b >> 3) & 15;
        n = b & 7;
        return (m + 1) * (1 << (n + plus1));
    endfunction

    // advance the reference model at each clock edge
    always @(posedge clk) begin
        if (!rst_n) begin
            pend_b = 'h44; act_b = 'h44; cnt = 0;
            pend_a = 'h44; act_a = 'h44; cnt_a = 0;
        end else begin
            bit et, eta;
            et  = core_en && (cnt   == period(act_b, 1) - 1);
            eta = core_en && (cnt_a == period(act_a, 0) - 1);
            if (!core_en || et)  cnt = 0;   else cnt++;
            if (!core_en || eta) cnt_a = 0; else cnt_a++;
            if (!core_en || et)  act_b = pend_b;
            if (!core_en || eta) act_a = pend_a;
            if (baud_wr) begin pend_b = baud_data; pend_a = baud_data; end
        end
    end

    // compare both builds against the model away from the edge
    always @(negedge clk) begin
        if (checking) begin
            bit et, eta;
            et  = rst_n && core_en && (cnt   == period(act_b, 1) - 1);
            eta = rst_n && core_en && (cnt_a == period(act_a, 0) - 1);
            total++;
            if (tick !== et) begin
                bad++;
                $display("FAIL %s tick=%b expected=%b t=%0t", cur_req, tick, et, $time);
            end
            total++;
            if (tick_alt !== eta) begin
                bad++;
                $display("FAIL %s/R7 alt tick=%b expected=%b t=%0t", cur_req, tick_alt, eta, $time);
            end
        end
    end

    task automatic cycles(input int n);
        repeat (n) @(posedge clk);
        #1;
    endtask

    task automatic write_rate(input logic [7:0] b);
        @(posedge clk); #1;
        baud_wr = 1'b1; baud_data = b;
        @(posedge clk); #1;
        baud_wr = 1'b0;
    endtask

    task automatic set_en(input logic v);
        @(posedge clk); #1;
        core_en = v;
    endtask

    // watchdog: a hung run counts as a failure and still reports
    initial begin
        #(200000 * 8);
        if (!done) begin
            total++; bad++;
            $display("FAIL watchdog expired");
            $display("test done: total=%0d bad=%0d", total, bad);
            $finish;
        end
    end

    initial begin
        checking = 1'b1;
        // R3: reset state and default 288-cycle period
        cur_req = "R3";
        cycles(4);
        rst_n = 1'b1;
        cycles(3);
        set_en(1'b1);
        cycles(700);
        // R5: write mid-period, old period must finish first
        cur_req = "R5";
        write_rate(8'h11);          // M=2 N=1: 12 / 6 clocks
        cycles(400);
        // R1: bit 7 set must not change the period; other field values
        cur_req = "R1";
        write_rate(8'h91);
        cycles(60);
        write_rate(8'h2B);          // M=5 N=3: 96 / 48 clocks
        cycles(300);
        // R2: short period, one-clock pulses
        cur_req = "R2";
        write_rate(8'h08);          // M=1 N=0: 4 / 2 clocks
        cycles(40);
        // R4: drop enable mid-period and restart
        cur_req = "R4";
        write_rate(8'h1A);          // M=3 N=2: 32 / 16 clocks
        cycles(45);
        set_en(1'b0);
        cycles(20);
        set_en(1'b1);
        cycles(100);
        // R6 / R8 / R7: write while disabled, minimum setting
        cur_req = "R6";
        set_en(1'b0);
        write_rate(8'h00);          // 2 / 1 clocks
        cycles(3);
        set_en(1'b1);
        cur_req = "R8";
        cycles(30);
        // R5: write on a short period, then switch to the maximum
        cur_req = "R5";
        write_rate(8'h7F);          // 4096 / 2048 clocks
        cur_req = "R8";
        cycles(9000);
        // R5: long period interrupted by a short rate write
        cur_req = "R5";
        write_rate(8'h09);          // M=1 N=1: 8 / 4 clocks
        cycles(4200);
        cur_req = "R7";
        write_rate(8'h33);          // M=6 N=3
        cycles(300);
        checking = 1'b0;
        done = 1'b1;
        $display("test done: total=%0d bad=%0d", total, bad);
        $finish;
    end
endmodule